// File: doc/BRIEF.md
# Real-Time Counter and Watchdog with a Shared Divider

This block holds an 8-bit free-running event counter and an 8-bit watchdog timer. One 8-bit divider is shared between them, and a single configuration bit decides which side owns it. When the counter owns the divider, the divider sits in front of the counter and slows the events that reach it. When the watchdog owns the divider, the divider sits behind the watchdog and lengthens the timeout. The side that does not own the divider runs at full rate.

The counter counts either system-clock cycles or edges on an external pin. The pin is synchronized before its edges are detected, and a configuration bit chooses the rising or the falling edge. When the counter wraps from all ones to zero, it raises a one-cycle interrupt request, but only while the interrupt enable is set. The watchdog counts ticks from a slow on-chip oscillator, which this block receives as a tick-enable input. It runs only while its enable strap is high. On timeout it issues a one-cycle reset pulse and starts again from zero.

All logic runs on the system clock, and every count step is a one-cycle enable. The divider itself cannot be read or written. Software can reach the counter through its write port and its read value.

Top module: `tmr_wdg_top`

## Requirements
- R1: While rst_n is low at a clock edge, cnt_o, irq_o and wd_rst_o are all zero after that edge.
- R2: With cfg_i[3]=0 the divider feeds the counter, and the counter advances once every 2^(cfg_i[2:0]+1) source events (1:2 up to 1:256).
- R3: With cfg_i[3]=1 the counter advances once per source event, undivided.
- R4: cfg_i[4]=0 selects system-clock cycles as the counter source. cfg_i[4]=1 selects edges of ext_pin_i after a two-flop synchronizer, one count per edge. cfg_i[5]=0 counts rising edges and cfg_i[5]=1 counts falling edges.
- R5: A counter wrap from 0xFF to 0x00 pulses irq_o high for exactly one cycle if cfg_i[6]=1. If cfg_i[6]=0, a wrap leaves irq_o low.
- R6: A cnt_wr_i cycle loads cnt_wdata_i into the counter, taking priority over any increment. In counter-owned mode (cfg_i[3]=0) it also clears the divider.
- R7: With cfg_i[3]=0, or with cfg_i[3]=1 and cfg_i[2:0]=0, wd_rst_o pulses for one cycle 256 ticks after a watchdog clear. The watchdog count then restarts from zero.
- R8: With cfg_i[3]=1 the timeout is stretched to 256·2^(cfg_i[2:0]) ticks, and each following timeout takes the same interval.
- R9: wd_clr_i zeroes the watchdog count, and in watchdog-owned mode it also zeroes the divider. Clears issued more often than once per timeout interval prevent any wd_rst_o pulse.
- R10: With wd_en_i low the watchdog holds at zero and wd_rst_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 7 | Configuration: [2:0] rate, [3] divider owner, [4] source, [5] edge, [6] interrupt enable |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| wd_en_i | input | 1 | Watchdog enable strap |
| wd_tick_i | input | 1 | One-cycle tick from the watchdog oscillator |
| wd_clr_i | input | 1 | Watchdog clear strobe |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Counter write data |
| cnt_o | output | 8 | Counter value |
| irq_o | output | 1 | Rollover interrupt request, one-cycle pulse |
| wd_rst_o | output | 1 | Watchdog timeout reset, one-cycle pulse |

## Verification
The assertions assume that cfg_i holds steady while a count window is open. They also assume that wd_tick_i and wd_clr_i are synchronous one-cycle strobes. Under those assumptions, no second wrap or second timeout can follow a first within one cycle. The bench changes cfg_i only at a falling edge before it opens a window with a counter write or a watchdog clear. It holds ext_pin_i at each level for four cycles, which is longer than the synchronizer and edge-detect latency, so no edge is lost or counted twice.

// File: rtl/tmr_wdg_pkg.sv
// Shared constants and the configuration field layout for the timer/watchdog.
// Assumes the divider is a power-of-two width so its rate field is log2 wide.
package tmr_wdg_pkg;
    localparam int DIV_W  = 8;
    localparam int RATE_W = $clog2(DIV_W);

    // Field layout of cfg_i, MSB first; bit 3 is the divider owner.
    typedef struct packed {
        logic              irq_en;     // [6] wrap interrupt enable
        logic              edge_fall;  // [5] 1 = falling pin edges
        logic              src_pin;    // [4] 1 = external pin source
        logic              div_to_wd;  // [3] 1 = divider owned by watchdog
        logic [RATE_W-1:0] rate;       // [2:0] divider tap select
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/pin_edge_sync.sv
// Synchronizes an asynchronous pin through SYNC_STAGES flops and produces
// one-cycle rise and fall pulses in the clk domain.
// Assumes the pin holds each level for more than SYNC_STAGES+1 cycles.
module pin_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] shreg;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[SH_W-2:0], pin_i};
    end

    assign rise_o =  shreg[SH_W-2] & ~shreg[SH_W-1];
    assign fall_o = ~shreg[SH_W-2] &  shreg[SH_W-1];
endmodule

// File: rtl/shared_divider.sv
// Binary divider shared between the counter and the watchdog.
// Pre mode: a pulse every 2^(rate+1) inputs. Post mode: every 2^rate, rate 0 bypasses.
// Assumes inc_i is a one-cycle enable; clr_i wins over inc_i.
module shared_divider #(
    parameter int DIV_W  = 8,
    parameter int RATE_W = $clog2(DIV_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              clr_i,
    input  logic              post_mode_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              pulse_o
);
    logic [DIV_W-1:0]  dcnt;
    logic [DIV_W-1:0]  low_ones;   // low_ones[k]: bits k..0 all set
    logic [RATE_W-1:0] rate_m1;
    logic              tap;

    // Carry chain: each stage tells whether the next increment clears bit k.
    genvar k;
    generate
        for (k = 0; k < DIV_W; k++) begin : g_ones
            if (k == 0) begin : g_first
                assign low_ones[k] = dcnt[k];
            end else begin : g_rest
                assign low_ones[k] = low_ones[k-1] & dcnt[k];
            end
        end
    endgenerate

    assign rate_m1 = rate_i - RATE_W'(1);

    // Select the tap: pre mode one bit higher than post mode.
    always_comb begin
        if (!post_mode_i)        tap = low_ones[rate_i];
        else if (rate_i == '0)   tap = 1'b1;
        else                     tap = low_ones[rate_m1];
    end

    assign pulse_o = inc_i & tap;

    // Advance or clear the divider.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) dcnt <= '0;
        else if (inc_i)      dcnt <= dcnt + DIV_W'(1);
    end

    AST_PRE_MIN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !post_mode_i) |-> dcnt[0]);  // R2
endmodule

// File: rtl/rt_counter.sv
// Loadable up-counter with a wrap interrupt request.
// Assumes inc_i is a one-cycle enable; a write wins over an increment.
module rt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             irq_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o
);
    // Load, advance, and flag a wrap when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
            irq_o <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (wr_i) begin
                cnt_o <= wdata_i;
            end else if (inc_i) begin
                cnt_o <= cnt_o + CNT_W'(1);
                irq_o <= irq_en_i & (&cnt_o);
            end
        end
    end

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cnt_o == '0));  // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);  // R5
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_o == $past(wdata_i)));  // R6
endmodule

// File: rtl/wd_core.sv
// Watchdog tick counter with an overflow strobe and a registered reset pulse.
// Assumes tick_i and clr_i are one-cycle strobes; timeout_i implies ovf_o.
module wd_core #(
    parameter int WD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic clr_i,
    input  logic timeout_i,
    output logic ovf_o,
    output logic wd_rst_o
);
    logic [WD_W-1:0] wcnt;

    assign ovf_o = en_i & tick_i & ~clr_i & (&wcnt);

    // Count ticks while enabled; hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || clr_i) wcnt <= '0;
        else if (tick_i)              wcnt <= wcnt + WD_W'(1);
    end

    // Register the timeout into a one-cycle reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) wd_rst_o <= 1'b0;
        else        wd_rst_o <= timeout_i;
    end

    AST_WD_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_o |=> !wd_rst_o);  // R7
    AST_WD_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_o |-> (wcnt == '0));  // R7
    AST_WD_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !wd_rst_o);  // R10
endmodule

// File: rtl/tmr_wdg_top.sv
// Real-time counter and watchdog sharing one divider, all on the system clock.
// cfg_i[3] gives the divider to the watchdog (1) or the counter (0).
// Assumes cfg_i is quasi-static and ext_pin_i changes slowly against clk.
module tmr_wdg_top
    import tmr_wdg_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int WD_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             ext_pin_i,
    input  logic             wd_en_i,
    input  logic             wd_tick_i,
    input  logic             wd_clr_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             wd_rst_o
);
    cfg_t cfg;
    logic pin_rise, pin_fall, src_evt;
    logic div_inc, div_clr, div_pulse;
    logic rtc_inc, wd_ovf, wd_timeout;

    assign cfg = cfg_t'(cfg_i);

    pin_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    // Pick the counter source event: every cycle or a chosen pin edge.
    always_comb begin
        if (!cfg.src_pin)       src_evt = 1'b1;
        else if (cfg.edge_fall) src_evt = pin_fall;
        else                    src_evt = pin_rise;
    end

    // Route the divider to its owner; the other path runs undivided.
    always_comb begin
        if (cfg.div_to_wd) begin
            div_inc    = wd_ovf;
            div_clr    = wd_clr_i | wd_timeout;
            rtc_inc    = src_evt;
            wd_timeout = div_pulse;
        end else begin
            div_inc    = src_evt;
            div_clr    = cnt_wr_i;
            rtc_inc    = div_pulse;
            wd_timeout = wd_ovf;
        end
    end

    shared_divider #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (div_inc),
        .clr_i       (div_clr),
        .post_mode_i (cfg.div_to_wd),
        .rate_i      (cfg.rate),
        .pulse_o     (div_pulse)
    );

    rt_counter #(.CNT_W(CNT_W)) u_rtc (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (rtc_inc),
        .wr_i     (cnt_wr_i),
        .wdata_i  (cnt_wdata_i),
        .irq_en_i (cfg.irq_en),
        .cnt_o    (cnt_o),
        .irq_o    (irq_o)
    );

    wd_core #(.WD_W(WD_W)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (wd_en_i),
        .tick_i    (wd_tick_i),
        .clr_i     (wd_clr_i),
        .timeout_i (wd_timeout),
        .ovf_o     (wd_ovf),
        .wd_rst_o  (wd_rst_o)
    );

    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.irq_en |=> !irq_o);  // R5
endmodule

// File: tb/sim_tmr_wdg_top.sv
`timescale 1ns/1ps
module sim_tmr_wdg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_i = '0;
    logic       ext_pin_i = 1'b0;
    logic       wd_en_i = 1'b0;
    logic       wd_tick_i = 1'b0;
    logic       wd_clr_i = 1'b0;
    logic       cnt_wr_i = 1'b0;
    logic [7:0] cnt_wdata_i = '0;
    logic [7:0] cnt_o;
    logic       irq_o;
    logic       wd_rst_o;

    always #2.5 clk = ~clk;

    tmr_wdg_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .ext_pin_i(ext_pin_i),
        .wd_en_i(wd_en_i), .wd_tick_i(wd_tick_i), .wd_clr_i(wd_clr_i),
        .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
        .cnt_o(cnt_o), .irq_o(irq_o), .wd_rst_o(wd_rst_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Vectors: cfg | wdata | cycles | expected count | expected wraps
    localparam logic [47:0] VECS [0:5] = '{
        48'h40_FE_0008_02_01,   // R2 rate0 1:2, R5 wrap
        48'h02_10_0028_15_00,   // R2 rate2 1:8
        48'h47_FF_012C_00_01,   // R2 rate7 1:256
        48'h48_F0_0014_04_01,   // R3 undivided
        48'h08_FA_000A_04_00,   // R3, R5 wrap without enable
        48'h43_FC_0046_00_01    // R2 rate3 1:16
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cnt(input logic [7:0] v);
        @(negedge clk);
        cnt_wr_i = 1'b1;
        cnt_wdata_i = v;
        @(negedge clk);
        cnt_wr_i = 1'b0;
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin_i = 1'b1; step(4);
            ext_pin_i = 1'b0; step(4);
        end
    endtask

    task automatic wd_clear();
        @(negedge clk);
        wd_clr_i = 1'b1;
        @(negedge clk);
        wd_clr_i = 1'b0;
    endtask

    task automatic time_to_rst(input int lim, output int cyc);
        cyc = 0;
        while (cyc < lim) begin
            @(negedge clk);
            cyc++;
            if (wd_rst_o) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            report();
        end
    end

    initial begin
        int cyc;
        int seen;
        // R1 reset state
        step(3);
        chk("R1 cnt in reset", cnt_o, 0);
        chk("R1 irq in reset", irq_o, 0);
        chk("R1 wd_rst in reset", wd_rst_o, 0);
        rst_n = 1'b1;

        // Table walk: divided and undivided counting, wraps
        for (int v = 0; v < 6; v++) begin
            cfg_i = VECS[v][46:40];
            write_cnt(VECS[v][39:32]);
            seen = 0;
            for (int i = 0; i < int'(VECS[v][31:16]); i++) begin
                @(negedge clk);
                if (irq_o) seen++;
            end
            chk($sformatf("R2/R3 vector %0d count", v), cnt_o, int'(VECS[v][15:8]));
            chk($sformatf("R5 vector %0d wraps", v), seen, int'(VECS[v][7:0]));
        end

        // R6: write clears the divider in counter-owned mode
        cfg_i = 7'h01;
        write_cnt(8'h20);
        step(3);
        chk("R6 before rewrite", cnt_o, 32);
        write_cnt(8'h20);
        step(3);
        chk("R6 divider cleared by write", cnt_o, 32);
        step(1);
        chk("R6 count after cleared divider", cnt_o, 33);

        // R4: external pin, rising then falling, undivided
        cfg_i = 7'h18;
        write_cnt(8'h00);
        pin_pulses(5);
        chk("R4 rising edges", cnt_o, 5);
        cfg_i = 7'h38;
        write_cnt(8'h00);
        pin_pulses(3);
        chk("R4 falling edges", cnt_o, 3);
        cfg_i = 7'h10;
        write_cnt(8'h00);
        pin_pulses(6);
        chk("R4 pin edges prescaled 1:2", cnt_o, 3);

        // R7: watchdog-owned, rate 0 bypass
        cfg_i = 7'h08;
        wd_tick_i = 1'b1;
        wd_en_i = 1'b1;
        wd_clear();
        time_to_rst(3000, cyc);
        chk("R7 timeout bypass", cyc, 256);
        step(1);
        chk("R7 single-cycle pulse", wd_rst_o, 0);

        // R8: postscaled 1:4, and a repeat interval
        cfg_i = 7'h0A;
        wd_clear();
        time_to_rst(3000, cyc);
        chk("R8 timeout 1:4", cyc, 1024);
        time_to_rst(3000, cyc);
        chk("R8 repeat interval", cyc, 1024);

        // R7: counter-owned divider leaves the watchdog undivided
        cfg_i = 7'h07;
        wd_clear();
        time_to_rst(3000, cyc);
        chk("R7 timeout counter-owned", cyc, 256);

        // R9: periodic clears keep the watchdog quiet
        cfg_i = 7'h08;
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            wd_clear();
            for (int j = 0; j < 200; j++) begin
                @(negedge clk);
                if (wd_rst_o) seen++;
            end
        end
        chk("R9 no timeout under clears", seen, 0);

        // R10: disabled watchdog never fires
        wd_en_i = 1'b0;
        seen = 0;
        for (int j = 0; j < 600; j++) begin
            @(negedge clk);
            if (wd_rst_o) seen++;
        end
        chk("R10 disabled watchdog", seen, 0);

        // R1: reset in mid-run
        cfg_i = 7'h48;
        step(5);
        rst_n = 1'b0;
        step(2);
        chk("R1 cnt after mid-run reset", cnt_o, 0);
        chk("R1 irq after mid-run reset", irq_o, 0);
        rst_n = 1'b1;

        report();
    end
endmodule